// File: doc/BRIEF.md
# Proximity Calibration Hold Timer

This block decides when the ambient-tracking calibration of a capacitive touch front end is allowed to run. It advances once per completed conversion sequence and sees two per-sequence flags: one says a user is near a sensor, the other says the measured value sits above the stored ambient value by more than the recalibration margin. Calibration is switched off at once when proximity is seen. After proximity clears, it is held off for a programmable number of sequences, and that number scales with the power mode. A programmable per-mode limit on consecutive out-of-range sequences triggers a forced recalibration.

The host sets two 4-bit hold counts (one per power mode), a 10-bit full-power recalibration limit and a 6-bit low-power recalibration limit. In full power, one hold step is 16 sequences. In low power, one hold step is 4 sequences. The block drives a level that gates calibration and a single-cycle pulse that requests recalibration.

Top module: `cal_hold_timer`

## Requirements
- R1: After reset, `cal_en` is 1 and `recal` is 0.
- R2: A sequence (`seq_done` high) with `prox` high drives `cal_en` to 0 in the next clock cycle.
- R3: With `low_power`=0, after a proximity sequence, `cal_en` stays 0 through the next `fp_hold_cnt`×16 non-proximity sequences. It returns to 1 one cycle after the non-proximity sequence that follows them.
- R4: With `low_power`=1, the rule of R3 applies with `lp_hold_cnt`×4 sequences.
- R5: A hold count of 0 re-enables calibration one cycle after the first non-proximity sequence.
- R6: `prox` and `exceed` are sampled only in cycles where `seq_done` is high; otherwise they have no effect on the outputs.
- R7: Let L be `fp_recal_cnt` when `low_power`=0 and `lp_recal_cnt` when `low_power`=1. After L consecutive sequences with `exceed` high, `recal` is 1 for exactly one cycle, the cycle after the L-th such sequence.
- R8: A sequence with `exceed` low restarts the consecutive count, so a full L further exceed sequences are needed.
- R9: A `recal` pulse drops `cal_en` to 0 in the same cycle. It restarts the hold period as proximity does, and it restarts the consecutive count, so continuous exceed pulses every L sequences.
- R10: A recalibration limit of 0 never produces a `recal` pulse.
- R11: Proximity seen again during a hold reloads the full hold period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seq_done | input | 1 | One-cycle pulse per finished conversion sequence |
| prox | input | 1 | Proximity seen in this sequence |
| exceed | input | 1 | Measured value above ambient by the recalibration margin |
| low_power | input | 1 | 0 = full power, 1 = low power |
| fp_hold_cnt | input | 4 | Full-power hold count, in steps of 16 sequences |
| lp_hold_cnt | input | 4 | Low-power hold count, in steps of 4 sequences |
| fp_recal_cnt | input | 10 | Full-power recalibration limit in sequences |
| lp_recal_cnt | input | 6 | Low-power recalibration limit in sequences |
| cal_en | output | 1 | Calibration allowed |
| recal | output | 1 | One-cycle forced-recalibration request |

## Verification
The hold path is swept over every hold count in both power modes. Each sweep uses one proximity sequence followed by clean sequences, and `cal_en` is checked after every sequence, so the ×16 and ×4 scalings and the off-by-one at the end of the hold are told apart. Proximity pulses without `seq_done`, and a proximity return in mid-hold, separate sampling and reload mistakes from counting mistakes. Continuous-exceed runs over a range of limits in each mode check the pulse position, the pulse repetition and the zero limit. The unused mode's limit is set to a small value, so a wrong mode selection shows at once. A run with one broken exceed sequence, and a run of exceed under a nonzero hold, check the count restart and the hold restart.

// File: rtl/chp_pkg.sv
package chp_pkg;
  typedef enum logic {PM_FULL = 1'b0, PM_LOW = 1'b1} pwr_mode_e;
endpackage

// File: rtl/chp_mode_sel.sv
// Selects the hold target and recalibration limit for the active power mode.
module chp_mode_sel
  import chp_pkg::*;
#(
  parameter int HOLD_W = 4,
  parameter int FP_SH  = 4,
  parameter int LP_SH  = 2,
  parameter int FPR_W  = 10,
  parameter int LPR_W  = 6,
  localparam int HT_W  = HOLD_W + FP_SH
) (
  input  pwr_mode_e           mode,
  input  logic [HOLD_W-1:0]   fp_hold,
  input  logic [HOLD_W-1:0]   lp_hold,
  input  logic [FPR_W-1:0]    fp_recal,
  input  logic [LPR_W-1:0]    lp_recal,
  output logic [HT_W-1:0]     hold_target,
  output logic [FPR_W-1:0]    recal_limit
);
  logic [HT_W-1:0] fp_target, lp_target;

  always_comb begin
    fp_target = HT_W'(fp_hold) << FP_SH;
    lp_target = HT_W'(lp_hold) << LP_SH;
    if (mode == PM_LOW) begin
      hold_target = lp_target;
      recal_limit = FPR_W'(lp_recal);
    end else begin
      hold_target = fp_target;
      recal_limit = fp_recal;
    end
  end
endmodule

// File: rtl/chp_recal_timer.sv
// Counts consecutive out-of-range sequences and issues the forced recalibration.
module chp_recal_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seq_done,
  input  logic             exceed,
  input  logic [CNT_W-1:0] limit,
  output logic             fire,
  output logic             recal
);
  logic [CNT_W-1:0] run_q, run_d;
  logic             run_en;
  logic             hit;
  logic             recal_q;

  always_comb begin
    hit    = (limit != '0) && (({1'b0, run_q} + 1'b1) >= {1'b0, limit});
    fire   = seq_done && exceed && hit;
    run_en = seq_done;
    if (!exceed || hit) run_d = '0;
    else                run_d = run_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (run_en) run_q <= run_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) recal_q <= 1'b0;
    else        recal_q <= fire;
  end

  assign recal = recal_q;

  // R7: a pulse only ever follows an exceed sequence
  a_r7_pulse_after_exceed: assert property (@(posedge clk) disable iff (!rst_n)
    recal |-> $past(seq_done && exceed));
  // R8: a clean sequence never produces a pulse
  a_r8_clean_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_done && !exceed) |=> !recal);
  // R10: a zero limit keeps the pulse silent
  a_r10_zero_limit_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_done && limit == '0) |=> !recal);
endmodule

// File: rtl/chp_hold_ctr.sv
// Hold-off counter that gates calibration after proximity or a forced recalibration.
module chp_hold_ctr #(
  parameter int HT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            seq_done,
  input  logic            prox,
  input  logic            restart,
  input  logic [HT_W-1:0] target,
  output logic            cal_en
);
  logic [HT_W-1:0] rem_q, rem_d;
  logic            en_q, en_d;
  logic            step_en;
  logic            load;

  always_comb begin
    step_en = seq_done;
    load    = seq_done && (prox || restart);
    rem_d   = rem_q;
    en_d    = en_q;
    if (load) begin
      rem_d = target;
      en_d  = 1'b0;
    end else if (rem_q == '0) begin
      en_d  = 1'b1;
    end else begin
      rem_d = rem_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      en_q  <= 1'b1;
    end else if (step_en) begin
      rem_q <= rem_d;
      en_q  <= en_d;
    end
  end

  assign cal_en = en_q;

  // R2: proximity blocks calibration on the next cycle
  a_r2_prox_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_done && prox) |=> !cal_en);
  // R5: an exhausted hold re-enables on a clean sequence
  a_r5_idle_enables: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_done && !prox && !restart && rem_q == '0) |=> cal_en);
  // R6: nothing changes between sequences
  a_r6_stable_between: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_done |=> $stable(cal_en));
endmodule

// File: rtl/cal_hold_timer.sv
module cal_hold_timer
  import chp_pkg::*;
#(
  parameter int HOLD_W = 4,
  parameter int FP_SH  = 4,
  parameter int LP_SH  = 2,
  parameter int FPR_W  = 10,
  parameter int LPR_W  = 6,
  localparam int HT_W  = HOLD_W + FP_SH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seq_done,
  input  logic             prox,
  input  logic             exceed,
  input  logic             low_power,
  input  logic [HOLD_W-1:0] fp_hold_cnt,
  input  logic [HOLD_W-1:0] lp_hold_cnt,
  input  logic [FPR_W-1:0] fp_recal_cnt,
  input  logic [LPR_W-1:0] lp_recal_cnt,
  output logic             cal_en,
  output logic             recal
);
  logic [1:0]       rst_sync;
  logic             rst_int_n;
  pwr_mode_e        mode;
  logic [HT_W-1:0]  hold_target;
  logic [FPR_W-1:0] recal_limit;
  logic             fire;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  assign mode = pwr_mode_e'(low_power);

  chp_mode_sel #(
    .HOLD_W(HOLD_W), .FP_SH(FP_SH), .LP_SH(LP_SH), .FPR_W(FPR_W), .LPR_W(LPR_W)
  ) u_sel (
    .mode        (mode),
    .fp_hold     (fp_hold_cnt),
    .lp_hold     (lp_hold_cnt),
    .fp_recal    (fp_recal_cnt),
    .lp_recal    (lp_recal_cnt),
    .hold_target (hold_target),
    .recal_limit (recal_limit)
  );

  chp_recal_timer #(.CNT_W(FPR_W)) u_recal (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .seq_done (seq_done),
    .exceed   (exceed),
    .limit    (recal_limit),
    .fire     (fire),
    .recal    (recal)
  );

  chp_hold_ctr #(.HT_W(HT_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .seq_done (seq_done),
    .prox     (prox),
    .restart  (fire),
    .target   (hold_target),
    .cal_en   (cal_en)
  );

  // R9: a recalibration pulse always coincides with calibration off
  a_r9_recal_blocks_cal: assert property (@(posedge clk) disable iff (!rst_int_n)
    recal |-> !cal_en);
  // R1: outputs idle right after reset release
  a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(rst_int_n) |-> (cal_en && !recal));
endmodule

// File: tb/cal_hold_timer_tb.sv
module cal_hold_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       seq_done, prox, exceed, low_power;
  logic [3:0] fp_hold_cnt, lp_hold_cnt;
  logic [9:0] fp_recal_cnt;
  logic [5:0] lp_recal_cnt;
  logic       cal_en, recal;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  cal_hold_timer u_dut (
    .clk(clk), .rst_n(rst_n), .seq_done(seq_done), .prox(prox), .exceed(exceed),
    .low_power(low_power), .fp_hold_cnt(fp_hold_cnt), .lp_hold_cnt(lp_hold_cnt),
    .fp_recal_cnt(fp_recal_cnt), .lp_recal_cnt(lp_recal_cnt),
    .cal_en(cal_en), .recal(recal)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic run_seq(input logic p, input logic e);
    @(negedge clk);
    seq_done = 1'b1; prox = p; exceed = e;
    @(negedge clk);
    seq_done = 1'b0; prox = 1'b0; exceed = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; seq_done = 0; prox = 0; exceed = 0; low_power = 0;
    fp_hold_cnt = 0; lp_hold_cnt = 0; fp_recal_cnt = 0; lp_recal_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 cal_en", cal_en, 1'b1);
    chk("R1 recal", recal, 1'b0);

    // hold sweep, both modes, every count (R2 R3 R4 R5)
    for (int m = 0; m < 2; m++) begin
      for (int n = 0; n < 16; n++) begin
        int tgt;
        low_power = logic'(m); fp_hold_cnt = 4'(n); lp_hold_cnt = 4'(n);
        tgt = (m == 1) ? n * 4 : n * 16;
        run_seq(1'b1, 1'b0);
        chk("R2", cal_en, 1'b0);
        for (int k = 1; k <= tgt + 1; k++) begin
          run_seq(1'b0, 1'b0);
          if (n == 0)      chk("R5", cal_en, 1'b1);
          else if (m == 1) chk("R4", cal_en, k == tgt + 1);
          else             chk("R3", cal_en, k == tgt + 1);
        end
      end
    end

    // R6: proximity without seq_done is ignored
    low_power = 0; fp_hold_cnt = 4'd3;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); prox = 1'b1; exceed = 1'b1;
      chk("R6", cal_en, 1'b1);
    end
    @(negedge clk); prox = 1'b0; exceed = 1'b0;
    run_seq(1'b0, 1'b0);
    chk("R6 after", cal_en, 1'b1);
    chk("R6 recal", recal, 1'b0);

    // R11: proximity during hold reloads it (low power, 1 x 4 = 4)
    low_power = 1; lp_hold_cnt = 4'd1;
    run_seq(1'b1, 1'b0);
    run_seq(1'b0, 1'b0); chk("R11", cal_en, 1'b0);
    run_seq(1'b0, 1'b0); chk("R11", cal_en, 1'b0);
    run_seq(1'b1, 1'b0); chk("R11", cal_en, 1'b0);
    for (int k = 1; k <= 5; k++) begin
      run_seq(1'b0, 1'b0);
      chk("R11", cal_en, k == 5);
    end

    // recalibration sweep (R7 R9 R10), hold counts zero
    fp_hold_cnt = 0; lp_hold_cnt = 0;
    for (int m = 0; m < 2; m++) begin
      for (int i = 0; i < 13; i++) begin
        int lim, runs;
        low_power = logic'(m);
        if (m == 1) lim = (i == 12) ? 63 : i;
        else case (i)
          0: lim = 0;  1: lim = 1;  2: lim = 2;  3: lim = 3;
          4: lim = 7;  5: lim = 100; 6: lim = 1023; default: lim = -1;
        endcase
        if (lim >= 0) begin
          if (m == 1) begin
            lp_recal_cnt = 6'(lim); fp_recal_cnt = (lim == 1) ? 10'd2 : 10'd1;
          end else begin
            fp_recal_cnt = 10'(lim); lp_recal_cnt = (lim == 1) ? 6'd2 : 6'd1;
          end
          run_seq(1'b0, 1'b0);
          runs = (lim == 0) ? 70 : 2 * lim + 1;
          for (int k = 1; k <= runs; k++) begin
            logic exp_r;
            exp_r = (lim != 0) && (k % lim == 0);
            run_seq(1'b0, 1'b1);
            if (lim == 0) chk("R10", recal, 1'b0);
            else          chk("R7", recal, exp_r);
            chk("R9 cal_en", cal_en, !exp_r);
            if (exp_r) begin
              @(negedge clk);
              chk("R7 width", recal, 1'b0);
            end
          end
          run_seq(1'b0, 1'b0);
          chk("R7 idle", recal, 1'b0);
        end
      end
    end

    // R8: a clean sequence restarts the count
    low_power = 1; lp_recal_cnt = 6'd5; fp_recal_cnt = 10'd1;
    run_seq(1'b0, 1'b0);
    for (int k = 0; k < 4; k++) begin run_seq(1'b0, 1'b1); chk("R8", recal, 1'b0); end
    run_seq(1'b0, 1'b0); chk("R8", recal, 1'b0);
    for (int k = 0; k < 4; k++) begin run_seq(1'b0, 1'b1); chk("R8", recal, 1'b0); end
    run_seq(1'b0, 1'b1); chk("R8", recal, 1'b1);

    // R9: a pulse restarts the hold (low power, 2 x 4 = 8)
    lp_hold_cnt = 4'd2; lp_recal_cnt = 6'd3;
    run_seq(1'b0, 1'b0);
    run_seq(1'b0, 1'b1); run_seq(1'b0, 1'b1);
    run_seq(1'b0, 1'b1);
    chk("R9 pulse", recal, 1'b1);
    chk("R9 cal_en", cal_en, 1'b0);
    for (int k = 1; k <= 9; k++) begin
      run_seq(1'b0, 1'b0);
      chk("R9 hold", cal_en, k == 9);
    end

    finish_run();
  end
endmodule